// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the program counter of a simple processor and works out its next value on every clock edge. Each cycle the decoder presents a control code that selects one of five actions. The actions are a plain step to the following address, a PC-relative conditional branch, a jump through a register value, a subroutine call and a subroutine return. The branch offset is a short two's complement immediate, because branch targets sit close to the branch. The register value and the call target are supplied from outside the block.

Return addresses are kept in a small internal memory that a stack pointer addresses. The stack grows toward lower addresses. A call decrements the pointer first and then stores the address of the instruction after the call at the new pointer. A return reads the entry at the pointer and then increments the pointer, so nested calls unwind in last-in, first-out order.

A two-state error machine records misuse of the stack. It starts in ST_CLEAN and takes the transition STACK_FAULT to ST_FAULT when a call arrives on a full stack or a return arrives on an empty one. It stays in ST_FAULT until reset. While it is in ST_FAULT, the PC and the stack keep working normally.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, the PC reads 0x0000, the stack pointer reads 16 (empty, one past the top entry 15) and the error flag reads 0.
- R2: Control code 0 (step) advances the PC by 1. Codes 5, 6 and 7 behave as code 0. In all four cases the branch-taken input has no effect.
- R3: Control code 1 (branch): when taken is 1, the next PC is PC plus the 8-bit two's complement offset sign-extended to 16 bits; when taken is 0, the next PC is PC plus 1.
- R4: Control code 2 (jump) loads the PC with the register operand.
- R5: Control code 3 (call) on a stack that is not full decrements the stack pointer, stores PC plus 1 at the new pointer and loads the PC with the call target.
- R6: Control code 4 (return) on a stack that is not empty loads the PC with the entry at the stack pointer and then increments the pointer.
- R7: Up to 16 nested calls are held, and the returns give back their return addresses in reverse order of the calls.
- R8: A call when the stack pointer is 0 (full) leaves the pointer and the stored entries unchanged, advances the PC by 1 and sets the error flag.
- R9: A return when the stack pointer is 16 (empty) leaves the pointer unchanged, advances the PC by 1 and sets the error flag.
- R10: Once set, the error flag stays at 1 until reset, and every other action keeps working.
- R11: All PC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 3 | Control code: 0 step, 1 branch, 2 jump, 3 call, 4 return |
| taken_i | input | 1 | Branch condition result, used only with code 1 |
| offset_i | input | 8 | Signed branch offset |
| reg_i | input | 16 | Register operand used as the jump destination |
| target_i | input | 16 | Subroutine address used by a call |
| pc_o | output | 16 | Current program counter |
| sp_o | output | 5 | Current stack pointer |
| stack_err_o | output | 1 | Sticky stack misuse flag |

## Verification
Every result registers on the single rising edge that samples the control code. The new PC, stack pointer and error flag are therefore all visible one clock after the inputs are applied, and a returned address is available on the edge right after the call that stored it. The bench applies each action at a falling edge, and at the next falling edge it compares all three outputs against a model that it updates arithmetically. This keeps every comparison exactly one edge behind its stimulus. The sweeps cover all 256 branch offsets, a full 16-deep call nest with overflow and underflow at both ends, and the wrap of the PC.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        CTL_STEP   = 3'd0,
        CTL_BRANCH = 3'd1,
        CTL_JUMP   = 3'd2,
        CTL_CALL   = 3'd3,
        CTL_RET    = 3'd4
    } ctl_e;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } err_state_e;

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int SP_W   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [SP_W-1:0]   sp_o,
    output logic [DATA_W-1:0] top_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   sp_dec;

    assign sp_dec  = sp_q - 1'b1;
    assign full_o  = (sp_q == '0);
    assign empty_o = (sp_q == SP_EMPTY);
    assign sp_o    = sp_q;
    assign top_o   = empty_o ? '0 : mem[sp_q[ADDR_W-1:0]];

    // pointer: pre-decrement on push, post-increment on pop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_EMPTY;
        end else if (push_i && !full_o) begin
            sp_q <= sp_dec;
        end else if (pop_i && !empty_o) begin
            sp_q <= sp_q + 1'b1;
        end
    end

    // storage: one write port at the decremented pointer
    always_ff @(posedge clk) begin
        if (push_i && !full_o) begin
            mem[sp_dec[ADDR_W-1:0]] <= push_data_i;
        end
    end

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic [2:0]       ctl_i,
    input  logic             taken_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [PC_W-1:0]  reg_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  top_i,
    input  logic             full_i,
    input  logic             empty_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic [PC_W-1:0]  ret_addr_o,
    output logic             push_o,
    output logic             pop_o,
    output logic             fault_o
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] off_ext;
    ctl_e            ctl;

    assign ctl        = ctl_e'(ctl_i);
    assign pc_inc     = pc_i + 1'b1;
    assign off_ext    = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    assign ret_addr_o = pc_inc;

    always_comb begin
        next_pc_o = pc_inc;
        push_o    = 1'b0;
        pop_o     = 1'b0;
        fault_o   = 1'b0;
        case (ctl)
            CTL_BRANCH: begin
                if (taken_i) next_pc_o = pc_i + off_ext;
            end
            CTL_JUMP: begin
                next_pc_o = reg_i;
            end
            CTL_CALL: begin
                if (full_i) begin
                    fault_o = 1'b1;
                end else begin
                    push_o    = 1'b1;
                    next_pc_o = target_i;
                end
            end
            CTL_RET: begin
                if (empty_i) begin
                    fault_o = 1'b1;
                end else begin
                    pop_o     = 1'b1;
                    next_pc_o = top_i;
                end
            end
            default: begin
                next_pc_o = pc_inc;
            end
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8,
    parameter int DEPTH = 16,
    localparam int SP_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ctl_i,
    input  logic             taken_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [PC_W-1:0]  reg_i,
    input  logic [PC_W-1:0]  target_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             stack_err_o
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] top_data;
    logic            push;
    logic            pop;
    logic            full;
    logic            empty;
    logic            fault;
    err_state_e      state_q;
    err_state_e      state_d;

    pcseq_next #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_next (
        .ctl_i      (ctl_i),
        .taken_i    (taken_i),
        .offset_i   (offset_i),
        .reg_i      (reg_i),
        .target_i   (target_i),
        .pc_i       (pc_q),
        .top_i      (top_data),
        .full_i     (full),
        .empty_i    (empty),
        .next_pc_o  (next_pc),
        .ret_addr_o (ret_addr),
        .push_o     (push),
        .pop_o      (pop),
        .fault_o    (fault)
    );

    pcseq_stack #(
        .DATA_W (PC_W),
        .DEPTH  (DEPTH),
        .SP_W   (SP_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (ret_addr),
        .sp_o        (sp_o),
        .top_o       (top_data),
        .full_o      (full),
        .empty_o     (empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= next_pc;
    end

    // error machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: if (fault) state_d = ST_FAULT;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    // error machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pc_o = pc_q;
        unique case (state_q)
            ST_CLEAN: stack_err_o = 1'b0;
            ST_FAULT: stack_err_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8,
    parameter int DEPTH = 16,
    parameter int SP_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ctl_i,
    input logic             taken_i,
    input logic [OFF_W-1:0] offset_i,
    input logic [PC_W-1:0]  reg_i,
    input logic [PC_W-1:0]  target_i,
    input logic [PC_W-1:0]  pc_o,
    input logic [SP_W-1:0]  sp_o,
    input logic             stack_err_o
);
    localparam logic [SP_W-1:0] SP_TOP = SP_W'(DEPTH);

    logic [PC_W-1:0] off_wide;
    logic            is_step;
    assign off_wide = {{(PC_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    assign is_step  = (ctl_i == 3'd0) || (ctl_i > 3'd4);

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        is_step |=> pc_o == $past(pc_o) + 1'b1); // R2
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == 3'd1 && taken_i) |=> pc_o == $past(pc_o + off_wide)); // R3
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i == 3'd2 |=> pc_o == $past(reg_i)); // R4
    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == 3'd3 && sp_o != '0) |=> (sp_o == $past(sp_o) - 1'b1) && (pc_o == $past(target_i))); // R5
    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == 3'd4 && sp_o != SP_TOP) |=> sp_o == $past(sp_o) + 1'b1); // R6
    AST_CALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == 3'd3 && sp_o == '0) |=> (sp_o == '0) && stack_err_o); // R8
    AST_RET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == 3'd4 && sp_o == SP_TOP) |=> (sp_o == SP_TOP) && stack_err_o); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err_o |=> stack_err_o); // R10
    AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o <= SP_TOP); // R7

endmodule

bind pc_sequencer pcseq_chk #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W),
    .DEPTH (DEPTH),
    .SP_W  (SP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_i       (ctl_i),
    .taken_i     (taken_i),
    .offset_i    (offset_i),
    .reg_i       (reg_i),
    .target_i    (target_i),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .stack_err_o (stack_err_o)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ctl = 3'd0;
    logic        taken = 1'b0;
    logic [7:0]  off = 8'd0;
    logic [15:0] rgv = 16'd0;
    logic [15:0] tgt = 16'd0;
    logic [15:0] pc;
    logic [4:0]  sp;
    logic        err;

    int checks = 0;
    int errors = 0;

    logic [15:0] mpc;
    int          msp;
    logic        merr;
    logic [15:0] mstk [16];

    always #2 clk = ~clk;

    pc_sequencer u0 (
        .clk (clk), .rst_n (rst_n), .ctl_i (ctl), .taken_i (taken),
        .offset_i (off), .reg_i (rgv), .target_i (tgt),
        .pc_o (pc), .sp_o (sp), .stack_err_o (err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "pc", 32'(pc), 32'(mpc));
        chk(req, "sp", 32'(sp), 32'(msp));
        chk(req, "err", 32'(err), 32'(merr));
    endtask

    task automatic op(input logic [2:0] c, input logic t, input logic [7:0] o,
                      input logic [15:0] r, input logic [15:0] g, input string req);
        ctl = c; taken = t; off = o; rgv = r; tgt = g;
        case (c)
            3'd1: mpc = t ? mpc + {{8{o[7]}}, o} : mpc + 16'd1;
            3'd2: mpc = r;
            3'd3: begin
                if (msp == 0) begin merr = 1'b1; mpc = mpc + 16'd1; end
                else begin msp--; mstk[msp] = mpc + 16'd1; mpc = g; end
            end
            3'd4: begin
                if (msp == 16) begin merr = 1'b1; mpc = mpc + 16'd1; end
                else begin mpc = mstk[msp]; msp++; end
            end
            default: mpc = mpc + 16'd1;
        endcase
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ctl = 3'd0; taken = 1'b0;
        mpc = 16'd0; msp = 16; merr = 1'b0;
        @(negedge clk); @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: idle after release, first step
        op(3'd0, 1'b0, 8'd0, 16'd0, 16'd0, "R1");
        // R2: step, taken ignored, unused codes
        op(3'd0, 1'b1, 8'hF0, 16'h1234, 16'h4321, "R2");
        for (int c = 5; c < 8; c++) op(3'(c), 1'b1, 8'h80, 16'hAAAA, 16'h5555, "R2");
        // R3: every offset, taken then not taken
        for (int o = 0; o < 256; o++) begin
            op(3'd1, 1'b1, 8'(o), 16'd0, 16'd0, "R3");
            op(3'd1, 1'b0, 8'(o), 16'd0, 16'd0, "R3");
        end
        // R4: jumps
        op(3'd2, 1'b0, 8'd0, 16'h8000, 16'd0, "R4");
        op(3'd2, 1'b1, 8'd5, 16'h0042, 16'd0, "R4");
        // R11: wrap both directions
        op(3'd2, 1'b0, 8'd0, 16'hFFFF, 16'd0, "R4");
        op(3'd0, 1'b0, 8'd0, 16'd0, 16'd0, "R11");
        op(3'd1, 1'b1, 8'hFF, 16'd0, 16'd0, "R11");
        op(3'd1, 1'b1, 8'h7F, 16'd0, 16'd0, "R11");
        // R5 R7: full nest of calls with a step between
        for (int i = 0; i < 16; i++) begin
            op(3'd3, 1'b0, 8'd0, 16'd0, 16'h1000 + 16'(i * 16), "R5");
            op(3'd0, 1'b0, 8'd0, 16'd0, 16'd0, "R7");
        end
        // R8: overflow twice, contents must survive
        op(3'd3, 1'b0, 8'd0, 16'd0, 16'hDEAD, "R8");
        op(3'd3, 1'b0, 8'd0, 16'd0, 16'hBEEF, "R8");
        // R6 R7: unwind all, branch between
        for (int i = 0; i < 16; i++) begin
            op(3'd4, 1'b0, 8'd0, 16'd0, 16'd0, "R6");
            op(3'd1, 1'b1, 8'd3, 16'd0, 16'd0, "R7");
        end
        // R9: underflow
        op(3'd4, 1'b0, 8'd0, 16'd0, 16'd0, "R9");
        // R10: flag sticky, calls still work
        op(3'd3, 1'b0, 8'd0, 16'd0, 16'h3000, "R10");
        op(3'd3, 1'b0, 8'd0, 16'd0, 16'h4000, "R10");
        op(3'd4, 1'b0, 8'd0, 16'd0, 16'd0, "R10");
        op(3'd4, 1'b0, 8'd0, 16'd0, 16'd0, "R10");
        op(3'd0, 1'b0, 8'd0, 16'd0, 16'd0, "R10");
        // R1: reset clears the flag; fresh underflow on empty stack
        do_reset();
        op(3'd4, 1'b0, 8'd0, 16'd0, 16'd0, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule